// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Lane Writes

This block is a synthesizable behavioural model of a small synchronous static RAM whose word is split into byte lanes. Every input (address, strobes, write controls, write data) is captured on the rising clock edge. A selected cycle either writes some or all of the lanes of one word or reads one word. Read data is returned through an output register one cycle after the read was sampled. The shared data pins of a real device are represented here by a write-data input, a read-data output and a drive flag that says when the device would be driving the pins.

An access begins on a strobe cycle, when the three chip-select inputs are also all active. The strobe cycle loads the address into an internal burst unit. The cycles that follow keep working on the same burst. On each of them an advance input steps a 2-bit counter, and that counter replaces the two low address bits. The order is either linear (wrapping add) or interleaved (exclusive-or), chosen by a mode input. A strobe cycle with any chip select inactive deselects the block and ends the burst.

Top module: `pbs_sram`

## Requirements
- R1: A read sampled at clock edge N is loaded into `rdata` at edge N+1. `rdata_drive` is then high for that cycle when `oe_n` is low.
- R2: `rdata_drive` is high only in the cycle after a selected read has loaded `rdata`, and only while `oe_n` is low. It is low after write cycles, idle cycles and deselect cycles.
- R3: With `all_wr_n` high and `bw_en_n` low, lane i (data bits i*BYTE_W upward, lane 0 least significant) is written exactly when `lane_wr_n[i]` is low. The other lanes of the word keep their contents.
- R4: With both `all_wr_n` and `bw_en_n` high, the cycle is a read and memory is unchanged, whatever `lane_wr_n` is.
- R5: With `all_wr_n` low, every lane is written, whatever `bw_en_n` and `lane_wr_n` are.
- R6: A strobe cycle (`load_n` low) is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise it performs no access and no write, and it ends the burst, so later non-strobe cycles stay idle until the next selected strobe.
- R7: The chip-select inputs are ignored on non-strobe cycles.
- R8: A selected strobe cycle accesses `addr_in` and clears the burst count. Each later non-strobe cycle accesses the word again. It first steps the count by one (mod 4) when `adv_n` is low, and keeps the count when `adv_n` is high. The accessed address is the upper bits of the loaded address with the low two bits taken from the burst order.
- R9: With `order_il`=0 the low two address bits are (loaded low bits + count) mod 4.
- R10: With `order_il`=1 the low two address bits are the loaded low bits XOR the count.
- R11: A read of a word written on the cycle just before returns the newly written data.
- R12: After reset, `rdata` is 0, `rdata_drive` is low, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | Word address, loaded on a strobe cycle |
| load_n | input | 1 | Strobe that samples the chip selects and starts a burst, active low |
| adv_n | input | 1 | Burst counter advance on non-strobe cycles, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| bw_en_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | LANES | Per-lane write request, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | LANES*BYTE_W | Write data, the inbound side of the shared data pins |
| rdata | output | LANES*BYTE_W | Registered read data, the outbound side of the shared data pins |
| rdata_drive | output | 1 | High when the data pins would be driven by the block |

## Verification
The bench targets the burst wrap points of both orders: a linear burst from low bits 2 and an interleaved burst from low bits 1. A design that used the wrong order, or carried into bit 2, reads the wrong word. It writes one lane at a time and then a global write with every lane request off. A decoder with the priorities mixed up shows a merged word where a lane should have kept its old value. Further cases are a write on the cycle before a read of the same word, a write attempted on a deselect strobe, and continuation cycles with chip selects dropped. A design that latched stale data, wrote while deselected or resampled the selects mid-burst returns the wrong word or drives the pins when it should not.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  localparam int unsigned PBS_STEP_W = 2;

  typedef enum logic [1:0] {
    PBS_IDLE  = 2'd0,
    PBS_READ  = 2'd1,
    PBS_WRITE = 2'd2
  } pbs_op_e;

  // Low address bits for a burst step: wrapping add or exclusive-or.
  function automatic logic [PBS_STEP_W-1:0] pbs_burst_lo(
    input logic [PBS_STEP_W-1:0] base_lo,
    input logic [PBS_STEP_W-1:0] step,
    input logic                  interleave
  );
    if (interleave) return base_lo ^ step;
    return base_lo + step;
  endfunction

endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
  import pbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic                  chips_on,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic                  adv,
  input  logic                  interleave,
  output logic                  access,
  output logic [ADDR_W-1:0]     eff_addr,
  output logic                  active,
  output logic [PBS_STEP_W-1:0] step
);

  logic                  active_q, active_nx;
  logic [ADDR_W-1:0]     base_q, base_nx;
  logic [PBS_STEP_W-1:0] step_q, step_nx;

  // R6 R7 R8: strobe samples the selects; other cycles follow the burst
  always_comb begin
    active_nx = active_q;
    base_nx   = base_q;
    step_nx   = step_q;
    access    = 1'b0;
    if (strobe) begin
      active_nx = chips_on;
      if (chips_on) begin
        base_nx = addr_in;
        step_nx = '0;
        access  = 1'b1;
      end
    end else if (active_q) begin
      access = 1'b1;
      if (adv) step_nx = step_q + 1'b1;
    end
  end

  // R9 R10: burst order picks the low address bits
  always_comb begin
    if (strobe) begin
      eff_addr = addr_in;
    end else begin
      eff_addr = {base_q[ADDR_W-1:PBS_STEP_W],
                  pbs_burst_lo(base_q[PBS_STEP_W-1:0], step_nx, interleave)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      step_q   <= '0;
    end else begin
      active_q <= active_nx;
      base_q   <= base_nx;
      step_q   <= step_nx;
    end
  end

  assign active = active_q;
  assign step   = step_q;

endmodule

// File: rtl/pbs_lane_decode.sv
module pbs_lane_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             all_wr_n,
  input  logic             bw_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_mask
);

  // R3 R4 R5: global write overrides; lane requests need the enable
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g] = ~all_wr_n | (~bw_en_n & ~lane_wr_n[g]);
  end

endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [LANES-1:0]          wr_mask,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*BYTE_W-1:0]   wdata,
  output logic [LANES*BYTE_W-1:0]   rdata
);

  localparam int unsigned DATA_W = LANES * BYTE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // R3: each lane is written only under its own mask bit
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[addr][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
      end
    end
  end

  // R1 R12: output register, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pbs_sram.sv
module pbs_sram
  import pbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic                      load_n,
  input  logic                      adv_n,
  input  logic                      order_il,
  input  logic                      sel_a_n,
  input  logic                      sel_b,
  input  logic                      sel_c_n,
  input  logic                      all_wr_n,
  input  logic                      bw_en_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      oe_n,
  input  logic [LANES*BYTE_W-1:0]   wdata,
  output logic [LANES*BYTE_W-1:0]   rdata,
  output logic                      rdata_drive
);

  localparam int unsigned DATA_W = LANES * BYTE_W;

  // Named internal events, also used by the bound checker
  logic                  chips_on;
  logic                  acc_fire;
  logic                  wr_fire;
  logic                  rd_fire;
  logic [ADDR_W-1:0]     eff_addr;
  logic [LANES-1:0]      lane_mask;
  logic                  burst_active;
  logic [PBS_STEP_W-1:0] burst_step;

  pbs_op_e           op_d, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_vld_q;

  assign chips_on = ~sel_a_n & sel_b & ~sel_c_n;

  pbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (~load_n),
    .chips_on   (chips_on),
    .addr_in    (addr_in),
    .adv        (~adv_n),
    .interleave (order_il),
    .access     (acc_fire),
    .eff_addr   (eff_addr),
    .active     (burst_active),
    .step       (burst_step)
  );

  pbs_lane_decode #(.LANES(LANES)) u_lanes (
    .all_wr_n  (all_wr_n),
    .bw_en_n   (bw_en_n),
    .lane_wr_n (lane_wr_n),
    .lane_mask (lane_mask)
  );

  assign wr_fire = acc_fire & (|lane_mask);
  assign rd_fire = acc_fire & ~(|lane_mask);

  always_comb begin
    if (wr_fire)      op_d = PBS_WRITE;
    else if (rd_fire) op_d = PBS_READ;
    else              op_d = PBS_IDLE;
  end

  // Input register stage: command, address, lanes and data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= PBS_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= op_d;
      addr_q  <= eff_addr;
      mask_q  <= lane_mask;
      wdata_q <= wdata;
    end
  end

  pbs_store #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op_q == PBS_WRITE),
    .wr_mask (mask_q),
    .rd_en   (op_q == PBS_READ),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .rdata   (rdata)
  );

  // R2: pins driven only after a read load, gated by the output enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= (op_q == PBS_READ);
  end

  assign rdata_drive = rd_vld_q & ~oe_n;

endmodule

// File: rtl/pbs_sram_chk.sv
module pbs_sram_chk #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             adv_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             all_wr_n,
  input logic             oe_n,
  input logic             rdata_drive,
  input logic             acc_fire,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic [LANES-1:0] lane_mask,
  input logic             burst_active,
  input logic [1:0]       burst_step
);

  logic sel_ok;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !sel_ok) |-> !acc_fire); // R6

  AST_IDLE_OUTSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !burst_active) |-> !acc_fire); // R6

  AST_STROBE_CLEARS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && sel_ok) |=> (burst_active && burst_step == 2'd0)); // R8

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && burst_active && !adv_n) |=> burst_step == 2'($past(burst_step) + 2'd1)); // R8

  AST_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && burst_active && adv_n) |=> $stable(burst_step)); // R8

  AST_SELECTS_IGNORED_MIDBURST: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && burst_active) |-> acc_fire); // R7

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !all_wr_n) |-> (wr_fire && (&lane_mask))); // R5

  AST_WRITE_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ##1 !rdata_drive); // R2

  AST_READ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ##1 (rdata_drive == !oe_n)); // R1

endmodule

bind pbs_sram pbs_sram_chk #(.LANES(LANES)) u_pbs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_n       (load_n),
  .adv_n        (adv_n),
  .sel_a_n      (sel_a_n),
  .sel_b        (sel_b),
  .sel_c_n      (sel_c_n),
  .all_wr_n     (all_wr_n),
  .oe_n         (oe_n),
  .rdata_drive  (rdata_drive),
  .acc_fire     (acc_fire),
  .wr_fire      (wr_fire),
  .rd_fire      (rd_fire),
  .lane_mask    (lane_mask),
  .burst_active (burst_active),
  .burst_step   (burst_step)
);

// File: tb/test_pbs_sram.sv
module test_pbs_sram;

  localparam int ADDR_W = 8;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [ADDR_W-1:0] addr_in;
  logic              load_n, adv_n, order_il;
  logic              sel_a_n, sel_b, sel_c_n;
  logic              all_wr_n, bw_en_n, oe_n;
  logic [LANES-1:0]  lane_wr_n;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rdata_drive;

  pbs_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) i_pbs_sram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .load_n(load_n), .adv_n(adv_n),
    .order_il(order_il), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .all_wr_n(all_wr_n), .bw_en_n(bw_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state
  logic [DATA_W-1:0] ref_mem [DEPTH];
  bit                m_act  = 1'b0;
  logic [ADDR_W-1:0] m_base = '0;
  int                m_step = 0;

  bit                p1_rd = 1'b0, p2_rd = 1'b0;
  logic [DATA_W-1:0] p1_d = '0, p2_d = '0;
  string             p1_t = "R1", p2_t = "R1";

  function automatic logic [1:0] order_lo(logic [1:0] b, int k, bit il);
    int s;
    if (il) return {b[1] ^ k[1], b[0] ^ k[0]};
    s = (int'(b) + k) % 4;
    return s[1:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(
    input logic [ADDR_W-1:0] a, input logic ld_n, input logic ad_n, input logic il,
    input logic sa_n, input logic sb, input logic sc_n,
    input logic aw_n, input logic bw_n, input logic [LANES-1:0] lw_n,
    input logic o_n, input logic [DATA_W-1:0] d, input string tag
  );
    bit                acc;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  msk;
    @(negedge clk);
    // outputs for the command issued two steps back, oe_n still held
    check("R2", 32'(rdata_drive), 32'(p2_rd & ~oe_n));
    if (p2_rd && !oe_n) check(p2_t, 32'(rdata), 32'(p2_d));
    addr_in = a; load_n = ld_n; adv_n = ad_n; order_il = il;
    sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
    all_wr_n = aw_n; bw_en_n = bw_n; lane_wr_n = lw_n; oe_n = o_n; wdata = d;
    acc = 1'b0;
    ea  = '0;
    if (!ld_n) begin
      m_act = !sa_n && sb && !sc_n;
      if (m_act) begin
        m_base = a; m_step = 0; acc = 1'b1; ea = a;
      end
    end else if (m_act) begin
      if (!ad_n) m_step = (m_step + 1) % 4;
      acc = 1'b1;
      ea  = {m_base[ADDR_W-1:2], order_lo(m_base[1:0], m_step, il)};
    end
    for (int l = 0; l < LANES; l++) msk[l] = !aw_n || (!bw_n && !lw_n[l]);
    p2_rd = p1_rd; p2_d = p1_d; p2_t = p1_t;
    p1_rd = acc && (msk == '0);
    p1_t  = tag;
    if (acc && msk != '0) begin
      for (int l = 0; l < LANES; l++)
        if (msk[l]) ref_mem[ea][l*BYTE_W +: BYTE_W] = d[l*BYTE_W +: BYTE_W];
    end
    if (p1_rd) p1_d = ref_mem[ea];
  endtask

  task automatic wr_global(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step(a, 0, 1, 0, 0, 1, 0, 0, 1, '1, 1, d, "R5");
  endtask

  task automatic rd_strobe(logic [ADDR_W-1:0] a, logic il, string tag);
    step(a, 0, 1, il, 0, 1, 0, 1, 1, '1, 0, '0, tag);
  endtask

  task automatic rd_next(logic ad_n, logic il, string tag);
    step('0, 1, ad_n, il, 1, 0, 1, 1, 1, '1, 0, '0, tag);
  endtask

  task automatic idle();
    step('0, 0, 1, 0, 1, 1, 0, 1, 1, '1, 0, '0, "R6");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; addr_in = '0; load_n = 1'b1; adv_n = 1'b1; order_il = 1'b0;
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; all_wr_n = 1'b1; bw_en_n = 1'b1;
    lane_wr_n = '1; oe_n = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R12", 32'(rdata_drive), 32'd0);
    check("R12", 32'(rdata), 32'd0);
    rst_n = 1'b1;

    // R12: no burst after reset, continuation cycles stay idle
    rd_next(0, 0, "R12");
    rd_next(0, 0, "R12");
    idle();
    @(negedge clk);
    check("R12", 32'(rdata_drive), 32'd0);

    // Fill memory: strobe write then three linear continuation writes,
    // selects dropped during the continuation (R7)
    for (int b = 0; b < DEPTH / 4; b++) begin
      wr_global(ADDR_W'(b * 4), DATA_W'($urandom));
      for (int k = 1; k < 4; k++)
        step('0, 1, 0, 0, 1, 0, 1, 0, 1, '1, 1, DATA_W'($urandom), "R7");
    end
    rd_strobe(8'h10, 0, "R7");
    rd_next(0, 0, "R7");

    // R3: single lanes
    step(8'h21, 0, 1, 0, 0, 1, 0, 1, 0, 2'b10, 1, 16'hA1B2, "R3");
    rd_strobe(8'h21, 0, "R3");
    step(8'h21, 0, 1, 0, 0, 1, 0, 1, 0, 2'b01, 1, 16'hC3D4, "R3");
    rd_strobe(8'h21, 0, "R3");

    // R4: lane requests without the enable do nothing
    step(8'h22, 0, 1, 0, 0, 1, 0, 1, 1, 2'b00, 1, 16'hFFFF, "R4");
    rd_strobe(8'h22, 0, "R4");

    // R5: global write with lane requests off
    step(8'h23, 0, 1, 0, 0, 1, 0, 0, 1, 2'b11, 1, 16'h5E6F, "R5");
    rd_strobe(8'h23, 0, "R5");

    // R11: read right after write
    wr_global(8'h30, 16'h1357);
    rd_strobe(8'h30, 0, "R11");

    // R6: write on a deselect strobe, then continuation stays idle
    step(8'h31, 0, 1, 0, 0, 0, 0, 0, 1, '1, 1, 16'hDEAD, "R6");
    rd_next(0, 0, "R6");
    rd_next(1, 0, "R6");
    rd_strobe(8'h31, 0, "R6");

    // R9 linear wrap from low bits 2, R8 hold
    rd_strobe(8'h46, 0, "R9");
    rd_next(0, 0, "R9");
    rd_next(1, 0, "R8");
    rd_next(0, 0, "R9");
    rd_next(0, 0, "R9");
    rd_next(0, 0, "R8");

    // R10 interleaved from low bits 1
    rd_strobe(8'h55, 1, "R10");
    rd_next(0, 1, "R10");
    rd_next(0, 1, "R10");
    rd_next(1, 1, "R8");
    rd_next(0, 1, "R10");

    // Random traffic, both orders
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 4000; i++) begin
        logic ld, wr_all, wr_lane;
        ld      = ($urandom % 10) < 4;
        wr_all  = ($urandom % 100) < 15;
        wr_lane = ($urandom % 100) < 30;
        step(ADDR_W'($urandom), ld ? 1'b0 : 1'b1, ($urandom % 10) < 7 ? 1'b0 : 1'b1,
             ph[0], ($urandom % 10) == 0, ($urandom % 10) != 0, ($urandom % 10) == 0,
             !wr_all, !wr_lane, LANES'($urandom), ($urandom % 100) < 15,
             DATA_W'($urandom), ph == 0 ? "R1" : "R10");
      end
    end

    repeat (3) idle();
    finish_run();
  end

endmodule